// File: doc/BRIEF.md
# Per-CPU Masked Device Interrupt Router

This block gathers level-sensitive device interrupt lines into a 64-bit raw request register. Each CPU has its own 64-bit enable mask. Each CPU gets one hard-interrupt output, which is high while the AND of its mask and the raw register has any bit set. The raw bits are wired by a fixed rule. PCI slot `s` using pin `p` lands on bit `(s+1)*4+p`, and the output of the cascaded legacy ISA controller lands on bit 55.

Software reaches the registers through a 32-bit CSR port, one 64-bit register at a time, in two halves. Writing the low half only parks the data in a shared holding latch. Writing the high half commits `{high, held low}` to the addressed register. Reading the low half returns the low 32 bits and copies the high 32 bits into the same latch. A following high-half read at any address returns the latch.

Top module: `irq_router`

## Requirements
- R1: After reset, all masks read as zero, the raw register reads as zero and every `cpu_irq` output is low.
- R2: Each raw bit is a level copy of its source line, registered once. A change on a line shows in the raw register, and in any output it affects, one clock later.
- R3: `pci_irq[s*4+p]` (slot `s`, pin `p` in 0..3) drives raw bit `(s+1)*4+p`.
- R4: `isa_irq` drives raw bit 55.
- R5: The masked view for CPU n reads as its mask ANDed with the raw register.
- R6: `cpu_irq[n]` is high exactly when CPU n's masked view is nonzero. It follows a mask commit one clock after the committing write.
- R7: Byte offsets of the registers (address bit 2 selects the high half): masks for CPU0..3 at 0x200, 0x240, 0x600, 0x640; masked views at 0x280, 0x2C0, 0x680, 0x6C0; raw register at 0x300.
- R8: A low-half write only loads the holding latch and changes no register. A high-half write commits `{wdata, latch}` to the register at that address.
- R9: Read data appears on `csr_rdata` one clock after `csr_rd`. A low-half read returns bits 31:0 and loads bits 63:32 into the latch. A high-half read returns the latch.
- R10: Writes to the raw or masked-view addresses change no register and no output.
- R11: A commit to CPU n's mask leaves the other CPUs' masks unchanged.
- R12: A low-half read at an unmapped address returns zero and leaves the latch unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pci_irq | input | NUM_SLOTS*4 | PCI interrupt lines, index slot*4+pin |
| isa_irq | input | 1 | Cascaded legacy ISA controller output |
| csr_rd | input | 1 | CSR read strobe |
| csr_wr | input | 1 | CSR write strobe (wins over read) |
| csr_addr | input | 12 | CSR byte offset |
| csr_wdata | input | 32 | CSR write data |
| csr_rdata | output | 32 | CSR read data, registered |
| cpu_irq | output | NUM_CPUS | Hard interrupt request per CPU |

## Verification
A wrong raw bit shows up one clock after the offending line toggles, both in the raw read-back and in the output of any CPU whose mask covers that bit. A mask that is corrupted or written to the wrong CPU shows up on that CPU's `cpu_irq` one clock after the commit, and in a mask read-back. A latch that is mis-sequenced only shows up on the next high-half access, either as wrong high-half read data or as a wrong committed mask value. The bench therefore always pairs each half-access with a read-back.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned CASCADE_BIT = 55;
  localparam logic [ADDR_W-1:0] RAW_OFFSET = 12'h300;

  // raw bit carrying a PCI slot/pin pair (R3)
  function automatic int unsigned pci_raw_bit(int unsigned slot, int unsigned pin);
    return (slot + 1) * 4 + pin;
  endfunction

  // mask register location for a CPU (R7)
  function automatic logic [ADDR_W-1:0] mask_offset(int unsigned cpu);
    logic [ADDR_W-1:0] bank;
    bank = (cpu >= 2) ? 12'h600 : 12'h200;
    return bank + ADDR_W'((cpu % 2) * 64);
  endfunction

  // masked view location sits 0x80 above the mask (R7)
  function automatic logic [ADDR_W-1:0] view_offset(int unsigned cpu);
    return mask_offset(cpu) + 12'h080;
  endfunction
endpackage

// File: rtl/irq_source_route.sv
module irq_source_route #(
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned REG_W     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS*4-1:0] pci_irq,
  input  logic                   isa_irq,
  output logic [REG_W-1:0]       raw_q
);
  import irq_router_pkg::*;
  localparam int unsigned IDX_W = $clog2(REG_W);

  logic [REG_W-1:0] raw_next;

  always_comb begin
    raw_next = '0;
    for (int unsigned s = 0; s < NUM_SLOTS; s++) begin
      for (int unsigned p = 0; p < 4; p++) begin
        raw_next[IDX_W'(pci_raw_bit(s, p))] = pci_irq[s*4+p];
      end
    end
    raw_next[IDX_W'(CASCADE_BIT)] = isa_irq;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= raw_next;
  end

  // R2: level following with one register of delay
  p_level_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q == $past(raw_next));
  // R4: cascade line lands on its fixed bit
  p_cascade_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q[CASCADE_BIT] == $past(isa_irq));
  // R3: first slot, first pin lands on bit 4
  p_slot0_pin0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> raw_q[4] == $past(pci_irq[0]));
endmodule

// File: rtl/irq_csr_port.sv
module irq_csr_port #(
  parameter int unsigned REG_W = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              csr_rd,
  input  logic                              csr_wr,
  input  logic [irq_router_pkg::ADDR_W-1:0] csr_addr,
  input  logic [REG_W/2-1:0]                csr_wdata,
  input  logic [REG_W-1:0]                  rd_value,
  input  logic                              rd_hit,
  output logic [irq_router_pkg::ADDR_W-1:0] reg_base,
  output logic                              commit,
  output logic [REG_W-1:0]                  commit_value,
  output logic [REG_W/2-1:0]                csr_rdata
);
  localparam int unsigned HALF_W = REG_W / 2;

  logic              is_hi;
  logic              rd_go;
  logic [HALF_W-1:0] half_latch;

  assign is_hi        = csr_addr[2];
  assign reg_base     = csr_addr & ~(irq_router_pkg::ADDR_W'(4));
  assign rd_go        = csr_rd && !csr_wr;
  assign commit       = csr_wr && is_hi;
  assign commit_value = {csr_wdata, half_latch};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_latch <= '0;
    end else if (csr_wr && !is_hi) begin
      half_latch <= csr_wdata;
    end else if (rd_go && !is_hi && rd_hit) begin
      half_latch <= rd_value[REG_W-1:HALF_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rdata <= '0;
    end else if (rd_go) begin
      if (is_hi)       csr_rdata <= half_latch;
      else if (rd_hit) csr_rdata <= rd_value[HALF_W-1:0];
      else             csr_rdata <= '0;
    end
  end

  // R9: a high-half read returns what the latch held
  p_hi_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && is_hi) |=> csr_rdata == $past(half_latch));
  // R9: a mapped low-half read captures the high half
  p_lo_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !is_hi && rd_hit) |=> half_latch == $past(rd_value[REG_W-1:HALF_W]));
  // R12: an unmapped low-half read leaves the latch alone and returns zero
  p_unmapped_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go && !is_hi && !rd_hit) |=> ($stable(half_latch) && csr_rdata == '0));
  // R8: a high-half write never disturbs the latch
  p_hi_write_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> $stable(half_latch));
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int unsigned NUM_CPUS = 4,
  parameter int unsigned REG_W    = 64
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              commit,
  input  logic [irq_router_pkg::ADDR_W-1:0] commit_base,
  input  logic [REG_W-1:0]                  commit_value,
  input  logic [REG_W-1:0]                  raw,
  output logic [NUM_CPUS-1:0][REG_W-1:0]    masks,
  output logic [NUM_CPUS-1:0][REG_W-1:0]    views,
  output logic [NUM_CPUS-1:0]               cpu_irq
);
  import irq_router_pkg::*;

  logic [NUM_CPUS-1:0] mask_hit;

  for (genvar n = 0; n < NUM_CPUS; n++) begin : g_cpu
    assign mask_hit[n] = commit && (commit_base == mask_offset(n));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           masks[n] <= '0;
      else if (mask_hit[n]) masks[n] <= commit_value;
    end

    assign views[n]   = masks[n] & raw;
    assign cpu_irq[n] = |views[n];

    // R11: no commit aimed at this CPU, no change to its mask
    p_isolation_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_hit[n] |=> $stable(masks[n]));
    // R6: an empty mask can never raise the output
    p_zero_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (masks[n] == '0) |-> !cpu_irq[n]);
    // R8: a commit installs the presented value
    p_commit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mask_hit[n] |=> masks[n] == $past(commit_value));
    // R1: the first cycle out of reset sees a cleared mask
    p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (masks[n] == '0 && !cpu_irq[n]));
  end

  // R11: at most one mask is targeted by any commit
  p_one_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_hit));
endmodule

// File: rtl/irq_router.sv
module irq_router #(
  parameter int unsigned NUM_CPUS  = 4,
  parameter int unsigned NUM_SLOTS = 12,
  parameter int unsigned REG_W     = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_SLOTS*4-1:0] pci_irq,
  input  logic                   isa_irq,
  input  logic                   csr_rd,
  input  logic                   csr_wr,
  input  logic [11:0]            csr_addr,
  input  logic [31:0]            csr_wdata,
  output logic [31:0]            csr_rdata,
  output logic [NUM_CPUS-1:0]    cpu_irq
);
  import irq_router_pkg::*;

  logic [REG_W-1:0]                raw_q;
  logic [ADDR_W-1:0]               reg_base;
  logic                            commit;
  logic [REG_W-1:0]                commit_value;
  logic [REG_W-1:0]                rd_value;
  logic                            rd_hit;
  logic [NUM_CPUS-1:0][REG_W-1:0]  masks;
  logic [NUM_CPUS-1:0][REG_W-1:0]  views;
  logic                            ro_write;

  irq_source_route #(.NUM_SLOTS(NUM_SLOTS), .REG_W(REG_W)) u_route (
    .clk(clk), .rst_n(rst_n), .pci_irq(pci_irq), .isa_irq(isa_irq), .raw_q(raw_q)
  );

  irq_csr_port #(.REG_W(REG_W)) u_csr (
    .clk(clk), .rst_n(rst_n), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .csr_addr(csr_addr), .csr_wdata(csr_wdata), .rd_value(rd_value),
    .rd_hit(rd_hit), .reg_base(reg_base), .commit(commit),
    .commit_value(commit_value), .csr_rdata(csr_rdata)
  );

  irq_mask_bank #(.NUM_CPUS(NUM_CPUS), .REG_W(REG_W)) u_masks (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_base(reg_base),
    .commit_value(commit_value), .raw(raw_q), .masks(masks),
    .views(views), .cpu_irq(cpu_irq)
  );

  // read decode (R7)
  always_comb begin
    rd_hit   = 1'b0;
    rd_value = '0;
    if (reg_base == RAW_OFFSET) begin
      rd_hit   = 1'b1;
      rd_value = raw_q;
    end
    for (int unsigned n = 0; n < NUM_CPUS; n++) begin
      if (reg_base == mask_offset(n)) begin
        rd_hit   = 1'b1;
        rd_value = masks[n];
      end
      if (reg_base == view_offset(n)) begin
        rd_hit   = 1'b1;
        rd_value = views[n];
      end
    end
  end

  // a commit aimed at a read-only register
  always_comb begin
    ro_write = commit && (reg_base == RAW_OFFSET);
    for (int unsigned n = 0; n < NUM_CPUS; n++) begin
      if (commit && reg_base == view_offset(n)) ro_write = 1'b1;
    end
  end

  // R10: read-only targets leave every mask untouched
  p_ro_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ro_write |=> $stable(masks));
  // R5: raw register idle means every view is empty
  p_view_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_q == '0) |-> (cpu_irq == '0));
endmodule

// File: tb/test_irq_router.sv
`timescale 1ns/1ps
module test_irq_router;
  localparam int NCPU = 4;
  localparam int NSLOT = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [NSLOT*4-1:0] pci_irq = '0;
  logic             isa_irq = 1'b0;
  logic             csr_rd = 1'b0;
  logic             csr_wr = 1'b0;
  logic [11:0]      csr_addr = '0;
  logic [31:0]      csr_wdata = '0;
  logic [31:0]      csr_rdata;
  logic [NCPU-1:0]  cpu_irq;

  irq_router i_irq_router (
    .clk(clk), .rst_n(rst_n), .pci_irq(pci_irq), .isa_irq(isa_irq),
    .csr_rd(csr_rd), .csr_wr(csr_wr), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .cpu_irq(cpu_irq)
  );

  always #2 clk = ~clk;

  int compared = 0;
  int mismatched = 0;
  logic [63:0] m_mask [NCPU];
  logic [31:0] m_latch = '0;
  logic [31:0] exp_q [$];
  string       req_q [$];
  logic        rd_seen = 1'b0;
  bit          done = 0;

  function automatic logic [63:0] exp_raw();
    logic [63:0] r = '0;
    for (int s = 0; s < NSLOT; s++)
      for (int p = 0; p < 4; p++)
        if (pci_irq[s*4+p]) r = r | (64'd1 << (4*s + 4 + p));
    if (isa_irq) r[55] = 1'b1;
    return r;
  endfunction

  function automatic logic [11:0] m_off(int n);
    case (n)
      0: return 12'h200;
      1: return 12'h240;
      2: return 12'h600;
      default: return 12'h640;
    endcase
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_seen <= csr_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) chk("queue", 64'd1, 64'd0);
      else chk(req_q.pop_front(), {32'd0, csr_rdata}, {32'd0, exp_q.pop_front()});
    end
  end

  task automatic csr_read(logic [11:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    csr_addr = a; csr_rd = 1'b1;
    exp_q.push_back(exp); req_q.push_back(req);
    @(negedge clk);
    csr_rd = 1'b0;
  endtask

  // read whose expectation comes from the bench register model
  task automatic model_read(logic [11:0] a, string req);
    logic [63:0] v;
    logic        hit;
    logic [11:0] b;
    b = a & ~12'h004; hit = 1'b0; v = '0;
    if (b == 12'h300) begin hit = 1'b1; v = exp_raw(); end
    for (int n = 0; n < NCPU; n++) begin
      if (b == m_off(n)) begin hit = 1'b1; v = m_mask[n]; end
      if (b == m_off(n) + 12'h080) begin hit = 1'b1; v = m_mask[n] & exp_raw(); end
    end
    if (a[2]) csr_read(a, m_latch, req);
    else begin
      csr_read(a, hit ? v[31:0] : 32'd0, req);
      if (hit) m_latch = v[63:32];
    end
  endtask

  task automatic csr_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wr = 1'b1;
    @(negedge clk);
    csr_wr = 1'b0;
    if (!a[2]) m_latch = d;
    else for (int n = 0; n < NCPU; n++)
      if ((a & ~12'h004) == m_off(n)) m_mask[n] = {d, m_latch};
  endtask

  task automatic write64(logic [11:0] a, logic [63:0] v);
    csr_write(a, v[31:0]);
    csr_write(a | 12'h004, v[63:32]);
  endtask

  task automatic check_irq(string req);
    logic [NCPU-1:0] e;
    @(negedge clk);
    for (int n = 0; n < NCPU; n++) e[n] = |(m_mask[n] & exp_raw());
    chk(req, {60'd0, cpu_irq}, {60'd0, e});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    for (int n = 0; n < NCPU; n++) m_mask[n] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check_irq("R1 outputs after reset");
    model_read(12'h300, "R1 raw low");
    model_read(12'h304, "R1 raw high");
    model_read(12'h600, "R1 mask cpu2 low");
    model_read(12'h644, "R1 mask cpu3 high via latch");

    // R3 mapping, R2 level following
    @(negedge clk); pci_irq[0] = 1'b1; pci_irq[3*4+2] = 1'b1; pci_irq[11*4+3] = 1'b1;
    @(negedge clk);
    csr_read(12'h300, 32'h0004_0010, "R3 slot0/pin0 and slot3/pin2 bits");
    csr_read(12'h304, 32'h0008_0000, "R3 slot11/pin3 at bit 51");
    // R4 cascade bit
    @(negedge clk); isa_irq = 1'b1;
    model_read(12'h300, "R4 raw low");
    csr_read(12'h304, 32'h0088_0000, "R4 cascade at bit 55");

    // R8 low write alone does nothing; R6 after commit
    csr_write(12'h200, 32'h0000_0010);
    check_irq("R8 low half write has no effect");
    csr_write(12'h204, 32'h0);
    chk("R6 cpu0 asserted", {63'd0, cpu_irq[0]}, 64'd1);
    check_irq("R11 other cpus quiet");
    model_read(12'h240, "R11 cpu1 mask untouched");

    // R5/R7 cpu3 cascade mask, view at 0x6C0
    write64(12'h640, 64'h0080_0000_0000_0000);
    check_irq("R6 cpu3 asserted");
    model_read(12'h6C0, "R5 cpu3 view low");
    model_read(12'h6C4, "R5 cpu3 view high");
    csr_read(12'h6C4, 32'h0080_0000, "R7 cpu3 view offset high");

    // R2 drop cascade: output falls one clock later
    @(negedge clk); isa_irq = 1'b0;
    @(negedge clk);
    chk("R2 cpu3 drops after line falls", {63'd0, cpu_irq[3]}, 64'd0);
    check_irq("R6 all outputs after drop");

    // R10 writes to read-only registers
    write64(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    write64(12'h280, 64'hFFFF_FFFF_FFFF_FFFF);
    write64(12'h6C0, 64'hFFFF_FFFF_FFFF_FFFF);
    check_irq("R10 outputs unchanged");
    model_read(12'h300, "R10 raw low unchanged");
    model_read(12'h304, "R10 raw high unchanged");
    model_read(12'h200, "R10 cpu0 mask low unchanged");
    model_read(12'h204, "R10 cpu0 mask high unchanged");

    // R12 unmapped read
    csr_read(12'h100, 32'h0, "R12 unmapped low reads zero");
    model_read(12'h104, "R12 latch kept after unmapped read");

    // R8/R9 full 64-bit commit and shared latch
    write64(12'h600, 64'hDEAD_BEEF_1234_5678);
    csr_read(12'h600, 32'h1234_5678, "R9 cpu2 mask low");
    csr_read(12'h604, 32'hDEAD_BEEF, "R8 cpu2 mask high");
    model_read(12'h600, "R9 recapture");
    csr_read(12'h304, 32'hDEAD_BEEF, "R9 high read returns shared latch");
    check_irq("R11 cpu2 mask vs raw");
    model_read(12'h680, "R5 cpu2 view low");
    model_read(12'h684, "R5 cpu2 view high");

    // R3 walk every slot/pin with all-ones mask on cpu1
    write64(12'h240, 64'hFFFF_FFFF_FFFF_FFFF);
    @(negedge clk); pci_irq = '0;
    for (int s = 0; s < NSLOT; s++) begin
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); pci_irq = '0; pci_irq[s*4+p] = 1'b1;
        @(negedge clk);
        model_read(12'h2C0, "R3 walk view low");
        model_read(12'h2C4, "R3 walk view high");
        check_irq("R6 walk outputs");
      end
    end
    @(negedge clk); pci_irq = '0;
    check_irq("R2 all lines idle");

    repeat (3) @(negedge clk);
    done = 1;
    finish_run();
  end
endmodule